// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit buses, called A and B. Each direction has its own capture register and its own capture strobe. A select for each direction chooses whether that direction forwards the live value of the opposite bus or the value held in its register. An enable for each direction decides whether that side's output drivers are turned on.

Each bus side is modelled as three separate signals: an input, an output value and an output enable. An outside bus resolver combines them, so the design needs no tri-state nets. Inside the block, each bus is "seen" as the block's own output whenever that side is driving, and as the external input otherwise.

When both directions are live and both sides drive, the two outputs feed each other. The block models this hold loop with a hold register. Outside loop mode, the hold register follows the A bus on every clock. Inside loop mode, it freezes, and both outputs carry its value. Capture strobes are sampled on the system clock. A 0-to-1 change between two consecutive clock edges stores the bus value present at the second edge.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both capture registers and the hold register to zero. After reset, stored-mode outputs read 0.
- R2: `b_oe` is high exactly when `b_drive_en` is 1 (active high). `a_oe` is high exactly when `a_drive_en_n` is 0 (active low).
- R3: With `sel_ab`=0 and outside loop mode, `b_out` equals the A bus as seen inside the block, in the same cycle.
- R4: With `sel_ab`=1, `b_out` equals the A-to-B capture register.
- R5: With `sel_ba`=1, `a_out` equals the B-to-A capture register. With `sel_ba`=0 and outside loop mode, `a_out` equals the B bus as seen inside the block.
- R6: `cap_ab` low at one clock edge and high at the next stores the seen A bus into the A-to-B register at that second edge. This happens whatever the selects and enables are.
- R7: `cap_ba` low at one clock edge and high at the next stores the seen B bus into the B-to-A register at that second edge. This happens whatever the selects and enables are.
- R8: A register that has no rising strobe at a clock edge keeps its value, even while its strobe stays high.
- R9: A bus that is being driven is seen inside the block as the block's own output for that side, not as the external input.
- R10: Loop mode is both selects 0 and both sides driving. In loop mode, `a_out` and `b_out` both equal the seen A bus value from the last clock edge before loop mode began. They keep that value while loop mode lasts, whatever the bus inputs do.
- R11: Capture works while both sides are disabled. The stored value appears on the output once stored mode and the enable are selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes, updates registers |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Value arriving from the external A bus |
| a_out | output | 8 | Value the block would drive onto A |
| a_oe | output | 1 | A-side output drivers on |
| b_in | input | 8 | Value arriving from the external B bus |
| b_out | output | 8 | Value the block would drive onto B |
| b_oe | output | 1 | B-side output drivers on |
| b_drive_en | input | 1 | Turns on B-side drivers, active high |
| a_drive_en_n | input | 1 | Turns on A-side drivers, active low |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| cap_ab | input | 1 | A-to-B capture strobe, acts on its rising change |
| cap_ba | input | 1 | B-to-A capture strobe, acts on its rising change |

## Verification
The assertions assume that the strobes, selects and enables change only between clock edges. They also assume that reset is held for at least two edges, so that every register is defined before checking starts. The bench applies all inputs at the falling clock edge. It holds the strobes low during reset. It drives random data, selects, enables and strobes from a fixed seed, so loop mode is entered and left many times. It adds a sweep of all sixteen enable and select combinations and directed capture sequences.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Direction source choice: live pass-through or registered copy.
  typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_sel_e;

  // Both sides drive and both directions are live: outputs feed each other.
  function automatic logic hold_loop(input logic a_drv_on, input logic b_drv_on,
                                     input logic s_ab, input logic s_ba);
    return a_drv_on && b_drv_on && (src_sel_e'(s_ab) == SRC_LIVE)
           && (src_sel_e'(s_ba) == SRC_LIVE);
  endfunction

  // Rising change of a sampled strobe.
  function automatic logic strobe_rise(input logic now_lvl, input logic last_lvl);
    return now_lvl && !last_lvl;
  endfunction

endpackage

// File: rtl/bus_xcvr_edge.sv
module bus_xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  import bus_xcvr_pkg::*;

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = strobe_rise(lvl, lvl_q);
endmodule

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (take) q <= d;
  end
endmodule

// File: rtl/bus_xcvr_route.sv
module bus_xcvr_route #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] reg_ab,
  input  logic [W-1:0] reg_ba,
  input  logic [W-1:0] hold,
  input  logic         a_on,
  input  logic         b_on,
  input  logic         s_ab,
  input  logic         s_ba,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] a_seen,
  output logic [W-1:0] b_seen,
  output logic         loop
);
  import bus_xcvr_pkg::*;

  // Each output is resolved without a combinational cycle. The loop case is
  // replaced by the hold register value.
  always_comb begin
    loop = hold_loop(a_on, b_on, s_ab, s_ba);

    if (s_ba)       a_drv = reg_ba;
    else if (!b_on) a_drv = b_in;
    else if (s_ab)  a_drv = reg_ab;
    else if (a_on)  a_drv = hold;
    else            a_drv = a_in;

    if (s_ab)       b_drv = reg_ab;
    else if (!a_on) b_drv = a_in;
    else if (s_ba)  b_drv = reg_ba;
    else if (b_on)  b_drv = hold;
    else            b_drv = b_in;

    a_seen = a_on ? a_drv : a_in;
    b_seen = b_on ? b_drv : b_in;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         b_drive_en,
  input  logic         a_drive_en_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba
);
  localparam int NDIR = 2;

  logic [W-1:0] reg_ab, reg_ba, hold_q;
  logic [W-1:0] a_seen, b_seen;
  logic         rise_ab, rise_ba, loop_mode;

  logic [NDIR-1:0]        strobe, rise;
  logic [NDIR-1:0][W-1:0] cap_d, cap_q;

  assign a_oe = !a_drive_en_n;
  assign b_oe = b_drive_en;

  assign strobe = {cap_ba, cap_ab};
  assign cap_d  = {b_seen, a_seen};

  // One strobe detector and one capture register per direction.
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    bus_xcvr_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (strobe[g]),
      .rise (rise[g])
    );
    bus_xcvr_store #(.W(W)) u_store (
      .clk  (clk),
      .rst  (rst),
      .take (rise[g]),
      .d    (cap_d[g]),
      .q    (cap_q[g])
    );
  end

  assign rise_ab = rise[0];
  assign rise_ba = rise[1];
  assign reg_ab  = cap_q[0];
  assign reg_ba  = cap_q[1];

  // Hold register follows the A bus until the loop closes.
  bus_xcvr_store #(.W(W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .take (!loop_mode),
    .d    (a_seen),
    .q    (hold_q)
  );

  bus_xcvr_route #(.W(W)) u_route (
    .a_in   (a_in),
    .b_in   (b_in),
    .reg_ab (reg_ab),
    .reg_ba (reg_ba),
    .hold   (hold_q),
    .a_on   (a_oe),
    .b_on   (b_oe),
    .s_ab   (sel_ab),
    .s_ba   (sel_ba),
    .a_drv  (a_out),
    .b_drv  (b_out),
    .a_seen (a_seen),
    .b_seen (b_seen),
    .loop   (loop_mode)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic         b_drive_en,
  input logic         a_drive_en_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         rise_ab,
  input logic         rise_ba,
  input logic         loop_mode,
  input logic [W-1:0] reg_ab,
  input logic [W-1:0] reg_ba,
  input logic [W-1:0] a_seen,
  input logic [W-1:0] b_seen
);
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (reg_ab == '0 && reg_ba == '0)); // R1
  AST_OE_POLARITY: assert property (@(posedge clk) disable iff (rst) (b_oe == b_drive_en) && (a_oe != a_drive_en_n)); // R2
  AST_LIVE_AB: assert property (@(posedge clk) disable iff (rst) (!sel_ab && !loop_mode) |-> b_out == a_seen); // R3
  AST_STORED_AB: assert property (@(posedge clk) disable iff (rst) sel_ab |-> b_out == reg_ab); // R4
  AST_STORED_BA: assert property (@(posedge clk) disable iff (rst) sel_ba |-> a_out == reg_ba); // R5
  AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (rst) rise_ab |=> reg_ab == $past(a_seen)); // R6
  AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (rst) rise_ba |=> reg_ba == $past(b_seen)); // R7
  AST_KEEP_AB: assert property (@(posedge clk) disable iff (rst) !rise_ab |=> $stable(reg_ab)); // R8
  AST_KEEP_BA: assert property (@(posedge clk) disable iff (rst) !rise_ba |=> $stable(reg_ba)); // R8
  AST_SEEN_A: assert property (@(posedge clk) disable iff (rst) a_oe |-> a_seen == a_out); // R9
  AST_SEEN_A_OFF: assert property (@(posedge clk) disable iff (rst) !a_oe |-> a_seen == a_in); // R9
  AST_LOOP_EQUAL: assert property (@(posedge clk) disable iff (rst) loop_mode |-> a_out == b_out); // R10
  AST_LOOP_STEADY: assert property (@(posedge clk) disable iff (rst) (loop_mode && $past(loop_mode) && !$past(rst)) |-> $stable(a_out)); // R10
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .a_in         (a_in),
  .a_out        (a_out),
  .b_out        (b_out),
  .a_oe         (a_oe),
  .b_oe         (b_oe),
  .b_drive_en   (b_drive_en),
  .a_drive_en_n (a_drive_en_n),
  .sel_ab       (sel_ab),
  .sel_ba       (sel_ba),
  .rise_ab      (rise_ab),
  .rise_ba      (rise_ba),
  .loop_mode    (loop_mode),
  .reg_ab       (reg_ab),
  .reg_ba       (reg_ba),
  .a_seen       (a_seen),
  .b_seen       (b_seen)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;
  logic       b_drive_en = 1'b0, a_drive_en_n = 1'b1;
  logic       sel_ab = 1'b0, sel_ba = 1'b0, cap_ab = 1'b0, cap_ba = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // Reference state
  logic [7:0] m_rab, m_rba, m_hold;
  logic       m_pab, m_pba;

  always #10 clk = ~clk;

  bus_xcvr_reg uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus resolution by iterating driver contributions until they settle.
  task automatic model(output logic [7:0] ea, output logic [7:0] eb,
                       output logic [7:0] sa, output logic [7:0] sb, output bit lp);
    bit aon = !a_drive_en_n, bon = b_drive_en;
    logic [7:0] abus = a_in, bbus = b_in;
    lp = aon && bon && !sel_ab && !sel_ba;
    if (lp) begin
      abus = m_hold; bbus = m_hold;
    end else begin
      for (int k = 0; k < 3; k++) begin
        abus = aon ? (sel_ba ? m_rba : bbus) : a_in;
        bbus = bon ? (sel_ab ? m_rab : abus) : b_in;
      end
    end
    ea = sel_ba ? m_rba : bbus;
    eb = sel_ab ? m_rab : abus;
    sa = abus; sb = bbus;
  endtask

  task automatic step(input logic [7:0] ai, input logic [7:0] bi, input logic enb,
                      input logic ena_n, input logic sab, input logic sba,
                      input logic cab, input logic cba);
    logic [7:0] ea, eb, sa, sb;
    bit lp;
    @(negedge clk);
    a_in = ai; b_in = bi; b_drive_en = enb; a_drive_en_n = ena_n;
    sel_ab = sab; sel_ba = sba; cap_ab = cab; cap_ba = cba;
    #2;
    model(ea, eb, sa, sb, lp);
    chk("R2", {7'd0, b_oe}, {7'd0, enb});
    chk("R2", {7'd0, a_oe}, {7'd0, !ena_n});
    if (lp) begin
      chk("R10", a_out, ea);
      chk("R10", b_out, eb);
    end else begin
      chk(sba ? "R5" : "R5", a_out, ea);
      if (sab) chk("R4", b_out, eb);
      else if (!ena_n) chk("R9", b_out, eb);
      else chk("R3", b_out, eb);
    end
    @(posedge clk);
    #1;
    if (cab && !m_pab) m_rab = sa;
    if (cba && !m_pba) m_rba = sb;
    if (!lp) m_hold = sa;
    m_pab = cab; m_pba = cba;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_rab = '0; m_rba = '0; m_hold = '0; m_pab = 1'b0; m_pba = 1'b0;

    // R1: stored mode right after reset shows cleared registers
    step(8'hFF, 8'hEE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1", a_out, 8'h00);
    chk("R1", b_out, 8'h00);

    // R11: capture with both sides off, then read back in stored mode
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(8'h5A, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(8'h11, 8'h22, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    #2;
    chk("R11", b_out, 8'h5A);
    chk("R7", a_out, 8'hA5);
    // R8: strobes still high, new data must not be stored
    step(8'h33, 8'h44, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8", b_out, 8'h5A);
    chk("R8", a_out, 8'hA5);

    // R6: capture while B live-driven from A (seen A is external input)
    step(8'h3C, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    step(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", b_out, 8'h3C);

    // R9 and R10: A driven from B, then close the loop
    step(8'h77, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", a_out, 8'hC3);
    step(8'h01, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10", a_out, 8'hC3);
    step(8'h81, 8'h18, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", b_out, 8'hC3);
    // captures in loop mode store the held value
    step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", b_out, 8'hC3);
    chk("R7", a_out, 8'hC3);

    // Sweep of every enable/select combination
    for (int k = 0; k < 16; k++)
      step(8'($urandom), 8'($urandom), k[0], k[1], k[2], k[3], 1'b0, 1'b0);

    // Random traffic
    for (int n = 0; n < 800; n++) begin
      logic [31:0] r = $urandom;
      step(8'($urandom), 8'($urandom), r[0], r[1], r[2], r[3], r[4], r[5]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule